// File: doc/BRIEF.md
# TDMA Air-Interface Frame Timebase

This block is the shared timing reference for a cellular physical layer that uses eight timeslots per frame. It counts a quarter-bit tick enable. From that count it keeps the position inside the current slot, the slot number and the absolute frame number. It also keeps the multiframe positions that schedulers use to place traffic, control and long-cycle tasks. A task scheduler reads these counts and the per-slot and per-frame strobes, and starts each processing unit in step with the air interface.

During synchronisation, software or a search engine loads the frame number, the slot and the offset inside the slot in a single cycle. All derived indices are realigned to the loaded frame number in that same cycle. In idle mode with discontinuous reception, a programmable target frame number raises a one-cycle wake pulse when that frame begins. Power control can use this pulse to bring the high-speed clocks back just before a broadcast or paging frame.

Top module: `tdma_timebase`

## Requirements
- R1: After reset, every count and index is zero and `slot_stb`, `frame_stb` and `wake_evt` are low.
- R2: `qb_pos` advances by one on each clock edge where `qb_tick` is high and `ld_en` is low, and it wraps from 624 to 0. With `qb_tick` and `ld_en` both low, no count changes.
- R3: `slot_no` advances by one when `qb_pos` wraps, and it wraps from 7 to 0. `slot_stb` is high for exactly the one cycle that follows that edge.
- R4: When slot 7 wraps to slot 0, the frame advances. `frame_stb` is high for exactly one cycle, and it is seen together with `slot_no`=0 and `qb_pos`=0.
- R5: `fn` counts from 0 up to 2,715,647 and then returns to 0.
- R6: At all times `mf26` equals `fn` mod 26, `mf51` equals `fn` mod 51 and `mf52` equals `fn` mod 52.
- R7: At all times `sf_idx` equals `fn` divided by 1326, rounded down (range 0 to 2047).
- R8: A cycle with `ld_en` high writes `ld_fn`, `ld_slot` and `ld_qb` into `fn`, `slot_no` and `qb_pos` on that edge. The derived indices follow the loaded frame number. A load takes priority over a tick, and that cycle produces no strobe and no wake pulse.
- R9: `wake_evt` pulses for one cycle, together with `frame_stb`, when a frame advance enters a frame equal to `wake_fn` while `wake_en` is high. With `wake_en` low it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| qb_tick | input | 1 | Quarter-bit tick enable |
| ld_en | input | 1 | Synchronous load of frame, slot and offset |
| ld_fn | input | 22 | Frame number to load (below 2,715,648) |
| ld_slot | input | 3 | Slot number to load |
| ld_qb | input | 10 | In-slot offset to load (below 625) |
| wake_en | input | 1 | Arms the frame-match wake event |
| wake_fn | input | 22 | Target frame number for the wake event |
| qb_pos | output | 10 | Quarter-bit position inside the slot |
| slot_no | output | 3 | Current timeslot |
| fn | output | 22 | Absolute frame number |
| mf26 | output | 5 | Frame number mod 26 |
| mf51 | output | 6 | Frame number mod 51 |
| mf52 | output | 6 | Frame number mod 52 |
| sf_idx | output | 11 | Superframe index |
| slot_stb | output | 1 | One-cycle pulse after a slot advance |
| frame_stb | output | 1 | One-cycle pulse after a frame advance |
| wake_evt | output | 1 | One-cycle frame-match wake pulse |

## Verification
The multiframe and superframe indices are separate wrapping counters, so a wrong modulus, a missed carry or a bad load realignment shows at the ports as a broken relation to `fn`. This can appear as early as the first frame advance after the fault, or directly after a load. A slip in the quarter-bit or slot counter moves `frame_stb` and `slot_no` by whole ticks, and this is seen at the next wrap. Directed loads place the counters just below the slot, superframe and hyperframe boundaries, so that these faults appear within a few ticks and not after millions of frames.

// File: rtl/tdma_time_pkg.sv
package tdma_time_pkg;
  function automatic int unsigned fn_mod(input int unsigned f, input int unsigned m);
    return f % m;
  endfunction

  function automatic int unsigned fn_div(input int unsigned f, input int unsigned d);
    return f / d;
  endfunction
endpackage

// File: rtl/tdma_mod_ctr.sv
module tdma_mod_ctr #(
  parameter int unsigned MOD = 8,
  parameter int unsigned W   = $clog2(MOD)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         at_max
);
  assign at_max = (q == W'(MOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (ld)     q <= ld_val;
    else if (inc)    q <= at_max ? '0 : q + 1'b1;
  end
endmodule

// File: rtl/tdma_wake_cmp.sv
module tdma_wake_cmp #(
  parameter int unsigned FN_W = 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic [FN_W-1:0] fn_cur,
  input  logic            fn_at_max,
  input  logic            arm,
  input  logic [FN_W-1:0] target,
  output logic            evt
);
  logic [FN_W-1:0] fn_next;
  logic            wake_hit;

  assign fn_next  = fn_at_max ? '0 : fn_cur + 1'b1;
  assign wake_hit = adv & arm & (fn_next == target);

  always_ff @(posedge clk) begin
    if (!rst_n) evt <= 1'b0;
    else        evt <= wake_hit;
  end
endmodule

// File: rtl/tdma_timebase.sv
module tdma_timebase
  import tdma_time_pkg::*;
#(
  parameter int unsigned QB_PER_SLOT = 625,
  parameter int unsigned SLOTS       = 8,
  parameter int unsigned MF_TCH      = 26,
  parameter int unsigned MF_CCH      = 51,
  parameter int unsigned MF_PD       = 52,
  parameter int unsigned SF_FRAMES   = 1326,
  parameter int unsigned HF_SF       = 2048
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 qb_tick,
  input  logic                                 ld_en,
  input  logic [$clog2(SF_FRAMES*HF_SF)-1:0]   ld_fn,
  input  logic [$clog2(SLOTS)-1:0]             ld_slot,
  input  logic [$clog2(QB_PER_SLOT)-1:0]       ld_qb,
  input  logic                                 wake_en,
  input  logic [$clog2(SF_FRAMES*HF_SF)-1:0]   wake_fn,
  output logic [$clog2(QB_PER_SLOT)-1:0]       qb_pos,
  output logic [$clog2(SLOTS)-1:0]             slot_no,
  output logic [$clog2(SF_FRAMES*HF_SF)-1:0]   fn,
  output logic [$clog2(MF_TCH)-1:0]            mf26,
  output logic [$clog2(MF_CCH)-1:0]            mf51,
  output logic [$clog2(MF_PD)-1:0]             mf52,
  output logic [$clog2(HF_SF)-1:0]             sf_idx,
  output logic                                 slot_stb,
  output logic                                 frame_stb,
  output logic                                 wake_evt
);
  localparam int unsigned FN_MOD = SF_FRAMES * HF_SF;
  localparam int unsigned QB_W   = $clog2(QB_PER_SLOT);
  localparam int unsigned SL_W   = $clog2(SLOTS);
  localparam int unsigned FN_W   = $clog2(FN_MOD);
  localparam int unsigned T_W    = $clog2(MF_TCH);
  localparam int unsigned C_W    = $clog2(MF_CCH);
  localparam int unsigned P_W    = $clog2(MF_PD);
  localparam int unsigned SP_W   = $clog2(SF_FRAMES);
  localparam int unsigned SI_W   = $clog2(HF_SF);

  // named internal events
  logic qb_max, slot_max, fn_max, sfp_max, mf26_max, mf51_max, mf52_max, sfi_max;
  logic slot_adv, frame_adv, sf_adv;
  logic [SP_W-1:0] sf_pos;

  assign slot_adv  = qb_tick & ~ld_en & qb_max;
  assign frame_adv = slot_adv & slot_max;
  assign sf_adv    = frame_adv & sfp_max;

  // realignment values for a load
  logic [T_W-1:0]  ld_mf26;
  logic [C_W-1:0]  ld_mf51;
  logic [P_W-1:0]  ld_mf52;
  logic [SP_W-1:0] ld_sfp;
  logic [SI_W-1:0] ld_sfi;
  assign ld_mf26 = T_W'(fn_mod(32'(ld_fn), MF_TCH));
  assign ld_mf51 = C_W'(fn_mod(32'(ld_fn), MF_CCH));
  assign ld_mf52 = P_W'(fn_mod(32'(ld_fn), MF_PD));
  assign ld_sfp  = SP_W'(fn_mod(32'(ld_fn), SF_FRAMES));
  assign ld_sfi  = SI_W'(fn_div(32'(ld_fn), SF_FRAMES));

  tdma_mod_ctr #(.MOD(QB_PER_SLOT), .W(QB_W)) u_qb (
    .clk(clk), .rst_n(rst_n), .ld(ld_en), .ld_val(ld_qb),
    .inc(qb_tick & ~ld_en), .q(qb_pos), .at_max(qb_max));

  tdma_mod_ctr #(.MOD(SLOTS), .W(SL_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .ld(ld_en), .ld_val(ld_slot),
    .inc(slot_adv), .q(slot_no), .at_max(slot_max));

  tdma_mod_ctr #(.MOD(FN_MOD), .W(FN_W)) u_fn (
    .clk(clk), .rst_n(rst_n), .ld(ld_en), .ld_val(ld_fn),
    .inc(frame_adv), .q(fn), .at_max(fn_max));

  tdma_mod_ctr #(.MOD(MF_TCH), .W(T_W)) u_mf26 (
    .clk(clk), .rst_n(rst_n), .ld(ld_en), .ld_val(ld_mf26),
    .inc(frame_adv), .q(mf26), .at_max(mf26_max));

  tdma_mod_ctr #(.MOD(MF_CCH), .W(C_W)) u_mf51 (
    .clk(clk), .rst_n(rst_n), .ld(ld_en), .ld_val(ld_mf51),
    .inc(frame_adv), .q(mf51), .at_max(mf51_max));

  tdma_mod_ctr #(.MOD(MF_PD), .W(P_W)) u_mf52 (
    .clk(clk), .rst_n(rst_n), .ld(ld_en), .ld_val(ld_mf52),
    .inc(frame_adv), .q(mf52), .at_max(mf52_max));

  tdma_mod_ctr #(.MOD(SF_FRAMES), .W(SP_W)) u_sfp (
    .clk(clk), .rst_n(rst_n), .ld(ld_en), .ld_val(ld_sfp),
    .inc(frame_adv), .q(sf_pos), .at_max(sfp_max));

  tdma_mod_ctr #(.MOD(HF_SF), .W(SI_W)) u_sfi (
    .clk(clk), .rst_n(rst_n), .ld(ld_en), .ld_val(ld_sfi),
    .inc(sf_adv), .q(sf_idx), .at_max(sfi_max));

  tdma_wake_cmp #(.FN_W(FN_W)) u_wake (
    .clk(clk), .rst_n(rst_n), .adv(frame_adv), .fn_cur(fn),
    .fn_at_max(fn_max), .arm(wake_en), .target(wake_fn), .evt(wake_evt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_stb  <= 1'b0;
      frame_stb <= 1'b0;
    end else begin
      slot_stb  <= slot_adv;
      frame_stb <= frame_adv;
    end
  end
endmodule

// File: rtl/tdma_timebase_chk.sv
module tdma_timebase_chk #(
  parameter int unsigned QB_PER_SLOT = 625,
  parameter int unsigned SLOTS       = 8,
  parameter int unsigned MF_TCH      = 26,
  parameter int unsigned MF_CCH      = 51,
  parameter int unsigned MF_PD       = 52,
  parameter int unsigned SF_FRAMES   = 1326,
  parameter int unsigned HF_SF       = 2048
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               qb_tick,
  input logic                               ld_en,
  input logic [$clog2(SF_FRAMES*HF_SF)-1:0] ld_fn,
  input logic [$clog2(SLOTS)-1:0]           ld_slot,
  input logic [$clog2(QB_PER_SLOT)-1:0]     ld_qb,
  input logic                               wake_en,
  input logic [$clog2(SF_FRAMES*HF_SF)-1:0] wake_fn,
  input logic [$clog2(QB_PER_SLOT)-1:0]     qb_pos,
  input logic [$clog2(SLOTS)-1:0]           slot_no,
  input logic [$clog2(SF_FRAMES*HF_SF)-1:0] fn,
  input logic [$clog2(MF_TCH)-1:0]          mf26,
  input logic [$clog2(MF_CCH)-1:0]          mf51,
  input logic [$clog2(MF_PD)-1:0]           mf52,
  input logic [$clog2(HF_SF)-1:0]           sf_idx,
  input logic                               slot_stb,
  input logic                               frame_stb,
  input logic                               wake_evt,
  input logic                               frame_adv
);
  localparam int unsigned FN_MOD = SF_FRAMES * HF_SF;

  p_qb_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!qb_tick && !ld_en) |=> ($stable(qb_pos) && $stable(slot_no) && $stable(fn)));

  p_slot_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (qb_tick && !ld_en && 32'(qb_pos) == QB_PER_SLOT - 1 && 32'(slot_no) != SLOTS - 1)
    |=> (32'(slot_no) == 32'($past(slot_no)) + 1 && slot_stb));

  p_frame_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> (slot_no == '0 && qb_pos == '0 && slot_stb));

  p_fn_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_adv && 32'(fn) == FN_MOD - 1) |=> (fn == '0));

  p_mf_rel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(mf26) == 32'(fn) % MF_TCH && 32'(mf51) == 32'(fn) % MF_CCH &&
     32'(mf52) == 32'(fn) % MF_PD));

  p_sf_rel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sf_idx) == 32'(fn) / SF_FRAMES);

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (fn == $past(ld_fn) && slot_no == $past(ld_slot) &&
               qb_pos == $past(ld_qb) && !slot_stb && !frame_stb && !wake_evt));

  p_wake_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |-> (frame_stb && fn == $past(wake_fn) && $past(wake_en)));
endmodule

bind tdma_timebase tdma_timebase_chk #(
  .QB_PER_SLOT(QB_PER_SLOT), .SLOTS(SLOTS), .MF_TCH(MF_TCH), .MF_CCH(MF_CCH),
  .MF_PD(MF_PD), .SF_FRAMES(SF_FRAMES), .HF_SF(HF_SF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .qb_tick(qb_tick), .ld_en(ld_en), .ld_fn(ld_fn),
  .ld_slot(ld_slot), .ld_qb(ld_qb), .wake_en(wake_en), .wake_fn(wake_fn),
  .qb_pos(qb_pos), .slot_no(slot_no), .fn(fn), .mf26(mf26), .mf51(mf51),
  .mf52(mf52), .sf_idx(sf_idx), .slot_stb(slot_stb), .frame_stb(frame_stb),
  .wake_evt(wake_evt), .frame_adv(frame_adv));

// File: tb/test_tdma_timebase.sv
module test_tdma_timebase;
  localparam longint FN_LIMIT = 2715648;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        qb_tick = 1'b0, ld_en = 1'b0, wake_en = 1'b0;
  logic [21:0] ld_fn = '0, wake_fn = '0;
  logic [2:0]  ld_slot = '0;
  logic [9:0]  ld_qb = '0;
  logic [9:0]  qb_pos;
  logic [2:0]  slot_no;
  logic [21:0] fn;
  logic [4:0]  mf26;
  logic [5:0]  mf51, mf52;
  logic [10:0] sf_idx;
  logic        slot_stb, frame_stb, wake_evt;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  longint m_qb = 0, m_slot = 0, m_fn = 0;
  bit e_sstb = 0, e_fstb = 0, e_wake = 0;

  always #5 clk = ~clk;

  tdma_timebase i_tdma_timebase (
    .clk(clk), .rst_n(rst_n), .qb_tick(qb_tick), .ld_en(ld_en), .ld_fn(ld_fn),
    .ld_slot(ld_slot), .ld_qb(ld_qb), .wake_en(wake_en), .wake_fn(wake_fn),
    .qb_pos(qb_pos), .slot_no(slot_no), .fn(fn), .mf26(mf26), .mf51(mf51),
    .mf52(mf52), .sf_idx(sf_idx), .slot_stb(slot_stb), .frame_stb(frame_stb),
    .wake_evt(wake_evt));

  // superframe index by repeated subtraction
  function automatic longint sf_of(input longint f);
    longint q = 0;
    while (f >= 1326) begin f -= 1326; q++; end
    return q;
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input bit was_ld);
    chk(was_ld ? "R8" : "R2", "qb_pos", qb_pos, m_qb);
    chk(was_ld ? "R8" : "R3", "slot_no", slot_no, m_slot);
    chk(was_ld ? "R8" : "R5", "fn", fn, m_fn);
    chk("R6", "mf26", mf26, m_fn % 26);
    chk("R6", "mf51", mf51, m_fn % 51);
    chk("R6", "mf52", mf52, m_fn % 52);
    chk("R7", "sf_idx", sf_idx, sf_of(m_fn));
    chk("R3", "slot_stb", slot_stb, e_sstb);
    chk("R4", "frame_stb", frame_stb, e_fstb);
    chk("R9", "wake_evt", wake_evt, e_wake);
  endtask

  // drive at negedge, let one edge pass, compare at the next negedge
  task automatic step(input bit tk, input bit ld, input longint lfn, input longint lsl,
                      input longint lqb, input bit wen, input longint wfn);
    qb_tick = tk; ld_en = ld; ld_fn = 22'(lfn); ld_slot = 3'(lsl); ld_qb = 10'(lqb);
    wake_en = wen; wake_fn = 22'(wfn);
    @(posedge clk);
    e_sstb = 0; e_fstb = 0; e_wake = 0;
    if (ld) begin
      m_qb = lqb; m_slot = lsl; m_fn = lfn;
    end else if (tk) begin
      if (m_qb == 624) begin
        m_qb = 0; e_sstb = 1;
        if (m_slot == 7) begin
          m_slot = 0; e_fstb = 1;
          m_fn = (m_fn == FN_LIMIT - 1) ? 0 : m_fn + 1;
          if (wen && m_fn == wfn) e_wake = 1;
        end else m_slot++;
      end else m_qb++;
    end
    @(negedge clk);
    compare_all(ld);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1", "reset fn", fn, 0);
    chk("R1", "reset slot", slot_no, 0);
    chk("R1", "reset qb", qb_pos, 0);
    chk("R1", "reset strobes", {slot_stb, frame_stb, wake_evt}, 0);

    // R2: holding without tick
    repeat (3) step(0, 0, 0, 0, 0, 0, 0);
    repeat (5) step(1, 0, 0, 0, 0, 0, 0);

    // R5 / R9: hyperframe wrap with wake armed on frame 0
    step(0, 1, FN_LIMIT - 1, 7, 622, 1, 0);
    repeat (4) step(1, 0, 0, 0, 0, 1, 0);
    chk("R5", "fn after hyperframe wrap", fn, 0);

    // R7: superframe boundary 1325 -> 1326
    step(0, 1, 1325, 7, 624, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R7", "sf_idx at 1326", sf_idx, 1);

    // R9: wake disarmed must not fire on matching frame
    step(0, 1, 99, 7, 624, 0, 100);
    step(1, 0, 0, 0, 0, 0, 100);
    chk("R9", "wake disarmed", wake_evt, 0);

    // R8: load overrides a tick at the slot boundary, no strobe
    step(0, 1, 500, 7, 624, 1, 501);
    step(1, 1, 777, 3, 10, 1, 501);
    chk("R8", "load over tick fn", fn, 777);

    // R4: a full slot wrap from slot 7 into the next frame
    step(0, 1, 51, 6, 620, 0, 0);
    repeat (630) step(1, 0, 0, 0, 0, 0, 0);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      bit tk = ($urandom % 10) < 8;
      bit ld = ($urandom % 150) == 0;
      longint lfn = $urandom % FN_LIMIT;
      longint lsl = $urandom % 8;
      longint lqb = 600 + ($urandom % 25);
      bit wen = $urandom % 2;
      longint wfn = ($urandom % 2) ? ((m_fn + 1) % FN_LIMIT) : ($urandom % FN_LIMIT);
      if (($urandom % 4) == 0) lfn = FN_LIMIT - 1 - ($urandom % 3);
      step(tk, ld, lfn, lsl, lqb, wen, wfn);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule